// File: doc/BRIEF.md
# Oversampled I2C Target Controller

This block is an I2C target (slave) that answers to a single 7-bit address fixed by a parameter. It never uses SCL as a clock. A system clock much faster than SCL samples both bus lines. A small sampler turns the samples into four one-cycle strobes: SCL rising, SCL falling, START and STOP. An eight-state machine advances only on these strobes. A START strobe overrides every state and sends the machine back to the address phase, which gives repeated-start support. A STOP strobe overrides every state and returns the machine to idle.

When the controller writes, each received byte is shown on `rx_byte` with a one-cycle `rx_valid` pulse, and the target keeps receiving bytes until STOP. When the controller reads, the target shifts out the byte present on `tx_byte` and pulses `tx_done` after the last bit. It then loads a new byte if the controller acknowledges, or goes silent until STOP if it does not. The SDA line is open-drain: the line is pulled low only while `sda_oe` is high and `sda_o` is low. `busy` marks traffic addressed to this target.

States and transitions:
- `ST_IDLE` waits for START.
- `ST_ADDR` shifts in the address and the direction bit, then goes to `ST_ACK` on a match or back to `ST_IDLE` on a mismatch.
- `ST_ACK` holds SDA low for one SCL period. It then goes to `ST_RX` if the controller writes, or to `ST_TX` if it reads.
- `ST_RX` receives 8 bits, then returns to `ST_ACK`.
- `ST_TX` sends 8 bits, then goes to `ST_TXACK_A`.
- `ST_TXACK_A` samples the controller's acknowledge on the SCL rise, then goes to `ST_TXACK_B`.
- `ST_TXACK_B` goes to `ST_TX` on an acknowledge, or to `ST_HOLD` on a not-acknowledge.
- `ST_HOLD` releases the bus until STOP.
- START in any state leads to `ST_ADDR`; STOP in any state leads to `ST_IDLE`.

Top module: `i2c_target`

## Requirements
- R1: After reset, `sda_oe`, `busy`, `rx_valid` and `tx_done` are all 0.
- R2: A STOP (SDA rising while SCL is high) in any state returns the target to idle: `busy` falls and SDA is released.
- R3: The first byte after START is read as 7 address bits (MSB first) followed by the direction bit (0 means the controller writes, 1 means it reads). Only an address equal to `ADDR` is acknowledged. On a mismatch SDA stays released and `busy` stays 0.
- R4: After a matching address byte, and after every byte the controller writes, the target pulls SDA low for one full SCL period (acknowledge).
- R5: Write data is sampled on SCL rising edges, MSB first. Each complete byte appears on `rx_byte` with a `rx_valid` pulse exactly one clock long. The target goes on receiving further bytes until STOP or START.
- R6: In a read, the byte from `tx_byte` is driven MSB first, with each bit changing only after an SCL falling edge. `tx_done` pulses once, for one clock, after the 8th bit.
- R7: If the controller acknowledges (SDA low) a transmitted byte, the next byte is taken from `tx_byte`. If it does not (SDA high), the target leaves SDA released for all later SCL cycles until STOP, and sends no `tx_done`.
- R8: A START while the target is busy, including in the middle of a byte, restarts the address phase for a new transaction.
- R9: `busy` is 1 from the acknowledge of a matching address until STOP, and 0 in idle and during the address phase.
- R10: SDA is driven only during an acknowledge or a transmitted bit; `sda_oe` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| sda_oe | output | 1 | SDA drive enable (open-drain) |
| sda_o | output | 1 | SDA value while enabled; 0 pulls the line low |
| tx_byte | input | 8 | Byte to send on the next read byte |
| tx_done | output | 1 | One-clock pulse when a byte has been sent |
| rx_byte | output | 8 | Last byte received from the controller |
| rx_valid | output | 1 | One-clock pulse when `rx_byte` is new |
| busy | output | 1 | Addressed activity in progress |

## Verification
The bench builds the block with `ADDR = 7'h5A` and two synchronizer stages, and runs SCL with a half period of 12 system clocks. With a 7-bit address, every possible address can be swept with both match and mismatch, which covers acknowledge and `busy` for all 128 cases. Sweeps of write and read data values, plus START and STOP placed in the middle of a byte and after a not-acknowledge, reach every state and every override transition. The reply is computed arithmetically from the address and data sent.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_RX,
        ST_TX,
        ST_TXACK_A,
        ST_TXACK_B,
        ST_HOLD
    } tgt_state_t;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;
endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output logic                 sda_s,
    output i2c_tgt_pkg::bus_evt_t evt
);
    logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
    logic scl_s, scl_q, sda_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sync <= '1;
                    sda_sync <= '1;
                end else begin
                    scl_sync <= scl_i;
                    sda_sync <= sda_i;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sync <= '1;
                    sda_sync <= '1;
                end else begin
                    scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
                    sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_s = scl_sync[SYNC_STAGES-1];
    assign sda_s = sda_sync[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        evt.scl_rise = scl_s & ~scl_q;
        evt.scl_fall = ~scl_s & scl_q;
        evt.start    = scl_s & scl_q & sda_q & ~sda_s;
        evt.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end

    // START and STOP never appear together with an SCL edge (R2, R8)
    assert_evt_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({evt.scl_rise, evt.scl_fall, evt.start, evt.stop}) <= 1);
endmodule

// File: rtl/i2c_target_ctrl.sv
module i2c_target_ctrl #(
    parameter logic [6:0] ADDR      = 7'h5A,
    parameter int         BYTE_BITS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sda_s,
    input  i2c_tgt_pkg::bus_evt_t evt,
    input  logic [BYTE_BITS-1:0]  tx_byte,
    output logic                  sda_oe,
    output logic                  sda_o,
    output logic                  tx_done,
    output logic [BYTE_BITS-1:0]  rx_byte,
    output logic                  rx_valid,
    output logic                  busy
);
    import i2c_tgt_pkg::*;

    localparam int CNT_W = $clog2(BYTE_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_BITS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_BITS - 1);

    tgt_state_t state, state_nx;
    logic [CNT_W-1:0]     bit_cnt;
    logic [BYTE_BITS-1:0] in_sh;
    logic [BYTE_BITS-1:0] out_sh;
    logic                 rd_dir;
    logic                 ctl_ack;
    logic                 addr_hit;

    assign addr_hit = (in_sh[BYTE_BITS-1:1] == ADDR);

    // next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    state_nx = ST_IDLE;
            ST_ADDR:    if (evt.scl_fall && bit_cnt == CNT_FULL)
                            state_nx = addr_hit ? ST_ACK : ST_IDLE;
            ST_ACK:     if (evt.scl_fall) state_nx = rd_dir ? ST_TX : ST_RX;
            ST_RX:      if (evt.scl_fall && bit_cnt == CNT_FULL) state_nx = ST_ACK;
            ST_TX:      if (evt.scl_fall && bit_cnt == CNT_LAST) state_nx = ST_TXACK_A;
            ST_TXACK_A: if (evt.scl_rise) state_nx = ST_TXACK_B;
            ST_TXACK_B: if (evt.scl_fall) state_nx = ctl_ack ? ST_TX : ST_HOLD;
            ST_HOLD:    state_nx = ST_HOLD;
        endcase
        if (evt.start) state_nx = ST_ADDR;
        if (evt.stop)  state_nx = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath: counters, shifters and pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            in_sh    <= '0;
            out_sh   <= '0;
            rd_dir   <= 1'b0;
            ctl_ack  <= 1'b0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
            tx_done  <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            tx_done  <= 1'b0;
            if (evt.start) begin
                bit_cnt <= '0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_RX: begin
                        if (evt.scl_rise) begin
                            in_sh   <= {in_sh[BYTE_BITS-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (evt.scl_fall && bit_cnt == CNT_FULL) begin
                            bit_cnt <= '0;
                            if (state == ST_ADDR) begin
                                rd_dir <= in_sh[0];
                            end else begin
                                rx_byte  <= in_sh;
                                rx_valid <= 1'b1;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (evt.scl_fall) begin
                            bit_cnt <= '0;
                            if (rd_dir) out_sh <= tx_byte;
                        end
                    end
                    ST_TX: begin
                        if (evt.scl_fall) begin
                            if (bit_cnt == CNT_LAST) begin
                                tx_done <= 1'b1;
                                bit_cnt <= '0;
                            end else begin
                                out_sh  <= {out_sh[BYTE_BITS-2:0], 1'b1};
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    ST_TXACK_A: if (evt.scl_rise) ctl_ack <= ~sda_s;
                    ST_TXACK_B: begin
                        if (evt.scl_fall && ctl_ack) begin
                            out_sh  <= tx_byte;
                            bit_cnt <= '0;
                        end
                    end
                    ST_IDLE, ST_HOLD: bit_cnt <= bit_cnt;
                endcase
            end
        end
    end

    // outputs decoded from the state
    always_comb begin
        sda_oe = 1'b0;
        sda_o  = 1'b1;
        busy   = 1'b1;
        unique case (state)
            ST_IDLE, ST_ADDR: busy = 1'b0;
            ST_ACK: begin
                sda_oe = 1'b1;
                sda_o  = 1'b0;
            end
            ST_TX: begin
                sda_oe = 1'b1;
                sda_o  = out_sh[BYTE_BITS-1];
            end
            ST_RX, ST_TXACK_A, ST_TXACK_B, ST_HOLD: busy = 1'b1;
        endcase
    end

    assert_stop_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        evt.stop |=> (state == ST_IDLE));

    assert_start_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evt.start |=> (state == ST_ADDR));

    assert_rx_then_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (state == ST_ACK));

    assert_rx_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_txdone_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> (state == ST_TXACK_A));

    // drive changes only after an SCL fall or a START/STOP override (R6, R4)
    assert_sda_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(evt.scl_fall) && !$past(evt.start) && !$past(evt.stop))
        |-> ($stable(sda_oe) && $stable(sda_o)));
endmodule

// File: rtl/i2c_target.sv
module i2c_target #(
    parameter logic [6:0] ADDR        = 7'h5A,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic       sda_o,
    input  logic [7:0] tx_byte,
    output logic       tx_done,
    output logic [7:0] rx_byte,
    output logic       rx_valid,
    output logic       busy
);
    localparam int BYTE_BITS = 8;

    i2c_tgt_pkg::bus_evt_t evt;
    logic sda_s;

    i2c_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .sda_s (sda_s),
        .evt   (evt)
    );

    i2c_target_ctrl #(.ADDR(ADDR), .BYTE_BITS(BYTE_BITS)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .sda_s    (sda_s),
        .evt      (evt),
        .tx_byte  (tx_byte),
        .sda_oe   (sda_oe),
        .sda_o    (sda_o),
        .tx_done  (tx_done),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid),
        .busy     (busy)
    );

    assert_drive_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> busy);

    assert_pulse_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_done && rx_valid));
endmodule

// File: tb/i2c_target_test.sv
module i2c_target_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 12;
    localparam logic [6:0] TGT = 7'h5A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_line;
    logic sda_oe, sda_o, tx_done, rx_valid, busy;
    logic [7:0] tx_byte = 8'h00, rx_byte;

    int n_chk = 0, n_fail = 0;
    int rx_cnt = 0, tx_cnt = 0, pulse_err = 0;
    logic [7:0] rx_last = 8'h00;
    logic rx_prev = 1'b0, tx_prev = 1'b0;
    logic smp_busy, smp_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line = sda_m & ~(sda_oe & ~sda_o);

    i2c_target #(.ADDR(TGT), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .sda_o(sda_o), .tx_byte(tx_byte), .tx_done(tx_done),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .busy(busy)
    );

    always @(negedge clk) begin
        if (rx_valid) begin rx_cnt++; rx_last = rx_byte; end
        if (tx_done) tx_cnt++;
        if ((rx_valid && rx_prev) || (tx_done && tx_prev)) pulse_err++;
        rx_prev = rx_valid;
        tx_prev = tx_done;
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        wait_clk(HALF/2); sda_m = b;
        wait_clk(HALF/2); scl_m = 1'b1;
        wait_clk(HALF);   scl_m = 1'b0;
    endtask

    task automatic bit_in(output logic b);
        wait_clk(HALF/2); sda_m = 1'b1;
        wait_clk(HALF/2); scl_m = 1'b1;
        wait_clk(HALF/2); b = sda_line; smp_busy = busy; smp_oe = sda_oe;
        wait_clk(HALF/2); scl_m = 1'b0;
    endtask

    task automatic gen_start();
        wait_clk(HALF/2); sda_m = 1'b1;
        wait_clk(HALF/2); scl_m = 1'b1;
        wait_clk(HALF);   sda_m = 1'b0;
        wait_clk(HALF);   scl_m = 1'b0;
    endtask

    task automatic gen_stop();
        wait_clk(HALF/2); sda_m = 1'b0;
        wait_clk(HALF/2); scl_m = 1'b1;
        wait_clk(HALF);   sda_m = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic l;
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
        bit_in(l);
        ack = ~l;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic m_ack, input logic [7:0] nxt);
        logic l;
        for (int i = 7; i >= 0; i--) begin
            bit_in(l);
            v[i] = l;
        end
        tx_byte = nxt;
        bit_out(~m_ack);
    endtask

    initial begin
        logic ack;
        logic [7:0] got;
        int rx0, tx0;

        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);
        // R1 reset state
        check("R1 sda_oe", sda_oe, 0);
        check("R1 busy", busy, 0);
        check("R1 pulses", {rx_valid, tx_done}, 0);

        // R3/R4/R9/R10 every address, write direction
        for (int a = 0; a < 128; a++) begin
            rx0 = rx_cnt;
            gen_start();
            check("R9 busy in address phase", busy, 0);
            send_byte({a[6:0], 1'b0}, ack);
            check("R3 R4 address ack", ack, (a == TGT) ? 1 : 0);
            check("R9 busy after address", smp_busy, (a == TGT) ? 1 : 0);
            check("R10 drive only when addressed", smp_oe & ~smp_busy, 0);
            gen_stop();
            check("R2 idle after stop", {busy, sda_oe}, 0);
            check("R3 no data on mismatch", rx_cnt - rx0, 0);
        end

        // R5 write sweep, several bytes in one transaction
        gen_start();
        send_byte({TGT, 1'b0}, ack);
        check("R4 write address ack", ack, 1);
        for (int k = 0; k < 16; k++) begin
            logic [7:0] v;
            v = 8'((k * 37) ^ 8'hA5);
            rx0 = rx_cnt;
            send_byte(v, ack);
            check("R4 data ack", ack, 1);
            check("R5 one pulse per byte", rx_cnt - rx0, 1);
            check("R5 rx_byte value", rx_last, v);
        end
        gen_stop();
        check("R2 busy after write stop", busy, 0);

        // R6/R7 read sweep with controller acks, last byte nacked
        tx_byte = 8'h00;
        gen_start();
        send_byte({TGT, 1'b1}, ack);
        check("R3 read address ack", ack, 1);
        for (int k = 0; k < 8; k++) begin
            logic [7:0] exp_v;
            exp_v = 8'((k * 53) + 8'h19);
            if (k == 0) exp_v = 8'h00;
            tx0 = tx_cnt;
            recv_byte(got, (k != 7), 8'(((k + 1) * 53) + 8'h19));
            check("R6 R7 read data", got, exp_v);
            check("R6 tx_done once", tx_cnt - tx0, 1);
        end
        // R7 after nack: released, no tx_done, still busy until stop
        tx0 = tx_cnt;
        recv_byte(got, 1'b0, 8'h00);
        check("R7 released after nack", got, 8'hFF);
        check("R7 no tx_done after nack", tx_cnt - tx0, 0);
        check("R9 busy while waiting stop", smp_busy, 1);
        gen_stop();
        check("R2 stop after nack", {busy, sda_oe}, 0);

        // R8 repeated start mid write byte, then read
        tx_byte = 8'hC3;
        gen_start();
        send_byte({TGT, 1'b0}, ack);
        bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
        rx0 = rx_cnt;
        gen_start();
        check("R8 address phase after restart", busy, 0);
        send_byte({TGT, 1'b1}, ack);
        check("R8 ack after repeated start", ack, 1);
        recv_byte(got, 1'b0, 8'h00);
        check("R8 read after repeated start", got, 8'hC3);
        check("R8 partial byte dropped", rx_cnt - rx0, 0);
        gen_stop();

        // R8 repeated start to a foreign address drops the target
        gen_start();
        send_byte({TGT, 1'b0}, ack);
        bit_out(1'b0); bit_out(1'b1);
        gen_start();
        send_byte({TGT ^ 7'h01, 1'b0}, ack);
        check("R8 foreign address after restart", ack, 0);
        check("R9 idle after foreign restart", smp_busy, 0);
        gen_stop();

        // R2 stop in the middle of a written byte
        gen_start();
        send_byte({TGT, 1'b0}, ack);
        rx0 = rx_cnt;
        bit_out(1'b1); bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
        gen_stop();
        check("R2 stop mid byte busy", busy, 0);
        check("R2 stop mid byte no data", rx_cnt - rx0, 0);

        check("R5 R6 pulse width one clock", pulse_err, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(negedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule